// File: doc/BRIEF.md
# SCL Phase Timer

This block times the two halves of every SCL period for an I2C master. A 3-bit prescaler select slows the reference clock by a power of two, and two 5-bit width values give the low and high halves in prescaled ticks. Each half also carries a fixed extra allowance for the SCL input synchroniser and glitch filter. That allowance is four ticks when the prescaler select is zero and three ticks otherwise.

The low half begins when the block pulls SCL low. After the low half it releases the line and waits until the synchronised, filtered SCL input reads high. Only then does the high half start counting, so a slave that holds SCL low stretches the clock. Two single-cycle strobes mark the points where the byte engine samples SDA and where it may change SDA. The block stays idle with SCL released while no transfer is active or while the module reset request is set. Frequency computation, rise and fall time compensation, and register range limits are left to software.

Top module: `scl_rate_gen`

## Requirements
- R1: While rst_n is low and in the first cycle after it, scl_drive_low, scl_rise_stb and scl_fall_stb are all 0.
- R2: With presc_sel = 0, the low half holds scl_drive_low at 1 for exactly (low_width + 4) clock cycles.
- R3: With presc_sel = s > 0, the low half lasts (low_width + 3) * 2^s clock cycles.
- R4: The high half lasts (high_width + K) * 2^s clock cycles, where K = 4 for s = 0 and 3 otherwise. It is measured from the cycle that shows scl_rise_stb to the cycle that shows scl_fall_stb, and SCL stays released throughout.
- R5: A width value of 0 in low_width or high_width gives the same timing as a value of 1.
- R6: After release, no scl_rise_stb appears and the high half does not begin while scl_in is held low, however long the hold lasts.
- R7: A high pulse on scl_in lasting a single clock cycle during the wait for high does not start the high half.
- R8: While xfer_active is 0 or soft_reset is 1, the cycle after that input is sampled shows scl_drive_low, scl_rise_stb and scl_fall_stb all at 0.
- R9: scl_fall_stb is a one-cycle pulse in the first cycle that scl_drive_low is 1. scl_rise_stb is a one-cycle pulse, and the two strobes are never both 1.
- R10: scl_rise_stb shows in the fourth clock cycle after the first cycle in which scl_in is high during the wait for high.
- R11: When a transfer becomes active, the next cycle starts a low half with scl_fall_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | Byte engine is in an active transfer |
| soft_reset | input | 1 | Module reset request; forces idle |
| presc_sel | input | 3 | Prescaler select; tick every 2^presc_sel cycles |
| low_width | input | 5 | Low half length in ticks, before the fixed allowance |
| high_width | input | 5 | High half length in ticks, before the fixed allowance |
| scl_in | input | 1 | SCL level sensed on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise_stb | output | 1 | One-cycle strobe at the sensed rising edge (SDA sample point) |
| scl_fall_stb | output | 1 | One-cycle strobe at the driven falling edge (SDA change point) |

## Verification
A wrong phase state or tick count shows at once on scl_drive_low. That pin goes low or releases a whole tick early or late, and it shows in the very cycle where the edge was due. A fault in the synchroniser or glitch filter moves scl_rise_stb by whole cycles after SCL is released, or lets a one-cycle pulse start the high half. A missing idle path leaves SCL pulled low one cycle after the transfer ends. A reference model that tracks the filter history and the remaining cycles of each half is compared with all three outputs on every cycle, so any of these faults is caught at its first wrong edge.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_in_filter.sv
module scl_in_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level
);
  logic sync1_q, sync2_q, level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= raw_in;
      sync2_q <= sync1_q;
    end
  end

  // accept a new level only when two successive samples agree
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  level_q <= 1'b1;
    else if (sync1_q == sync2_q) level_q <= sync2_q;
  end

  assign level = level_q;
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, last_val;

  always_comb begin
    last_val = CNT_W'((1 << sel) - 1);
    tick     = (cnt_q == last_val);
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int WID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             line_high,
  input  logic [SEL_W-1:0] sel,
  input  logic [WID_W-1:0] low_w,
  input  logic [WID_W-1:0] high_w,
  output logic             restart,
  output logic             drive_low,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int PC_W = WID_W + 1;

  scl_phase_e      ph_q, ph_d;
  logic [PC_W-1:0] cnt_q, cnt_d;
  logic [PC_W-1:0] extra, lo_last, hi_last;
  logic [WID_W-1:0] lo_eff, hi_eff;
  logic            drv_d, rise_d, fall_d;
  logic            drv_q, rise_q, fall_q;

  always_comb begin
    lo_eff  = (low_w  == '0) ? WID_W'(1) : low_w;
    hi_eff  = (high_w == '0) ? WID_W'(1) : high_w;
    extra   = (sel == '0) ? PC_W'(4) : PC_W'(3);
    lo_last = {1'b0, lo_eff} + extra - 1'b1;
    hi_last = {1'b0, hi_eff} + extra - 1'b1;
  end

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    drv_d   = drv_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    restart = 1'b0;
    if (!active) begin
      ph_d    = PH_IDLE;
      cnt_d   = '0;
      drv_d   = 1'b0;
      restart = 1'b1;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d    = PH_LOW;
          cnt_d   = '0;
          drv_d   = 1'b1;
          fall_d  = 1'b1;
          restart = 1'b1;
        end
        PH_LOW: begin
          if (tick) begin
            if (cnt_q == lo_last) begin
              ph_d    = PH_WAIT;
              cnt_d   = '0;
              drv_d   = 1'b0;
              restart = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        PH_WAIT: begin
          restart = 1'b1;
          if (line_high) begin
            ph_d   = PH_HIGH;
            cnt_d  = '0;
            rise_d = 1'b1;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            if (cnt_q == hi_last) begin
              ph_d    = PH_LOW;
              cnt_d   = '0;
              drv_d   = 1'b1;
              fall_d  = 1'b1;
              restart = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      drv_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      drv_q  <= drv_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign drive_low = drv_q;
  assign rise_stb  = rise_q;
  assign fall_stb  = fall_q;
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int SEL_W = 3,
  parameter int WID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic             soft_reset,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic [WID_W-1:0] low_width,
  input  logic [WID_W-1:0] high_width,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             scl_rise_stb,
  output logic             scl_fall_stb
);
  logic active, tick, restart, line_high;

  assign active = xfer_active & ~soft_reset;

  scl_in_filter u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (scl_in),
    .level  (line_high)
  );

  scl_tick_div #(.SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .sel     (presc_sel),
    .tick    (tick)
  );

  scl_phase_ctrl #(.SEL_W(SEL_W), .WID_W(WID_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .tick      (tick),
    .line_high (line_high),
    .sel       (presc_sel),
    .low_w     (low_width),
    .high_w    (high_width),
    .restart   (restart),
    .drive_low (scl_drive_low),
    .rise_stb  (scl_rise_stb),
    .fall_stb  (scl_fall_stb)
  );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_active,
  input logic soft_reset,
  input logic scl_drive_low,
  input logic scl_rise_stb,
  input logic scl_fall_stb
);
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise_stb && scl_fall_stb)); // R9
  AST_FALL_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_stb |-> scl_drive_low); // R9
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_stb |=> !scl_fall_stb); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active || soft_reset) |=> (!scl_drive_low && !scl_rise_stb && !scl_fall_stb)); // R8
  AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_stb |-> !scl_drive_low); // R4
  AST_HIGH_START_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_stb |=> (!scl_drive_low && !scl_rise_stb)); // R4
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xfer_active   (xfer_active),
  .soft_reset    (soft_reset),
  .scl_drive_low (scl_drive_low),
  .scl_rise_stb  (scl_rise_stb),
  .scl_fall_stb  (scl_fall_stb)
);

// File: tb/scl_rate_gen_test.sv
`timescale 1ns/1ps
module scl_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_active = 1'b0;
  logic       soft_reset = 1'b0;
  logic [2:0] presc_sel = 3'd0;
  logic [4:0] low_width = 5'd1;
  logic [4:0] high_width = 5'd1;
  logic       stretch = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, scl_rise_stb, scl_fall_stb;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign scl_in = ~scl_drive_low & ~stretch;

  scl_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .soft_reset(soft_reset),
    .presc_sel(presc_sel), .low_width(low_width), .high_width(high_width),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: filter history plus remaining cycles in the current half
  int  m_ph;         // 0 idle, 1 low, 2 wait, 3 high
  int  m_rem;
  bit  m_s1, m_s2, m_f;
  bit  e_drive, e_rise, e_fall;
  bit  smp_scl;

  function automatic int half_len(input int w, input int sel);
    int eff = (w == 0) ? 1 : w;
    int k   = (sel == 0) ? 4 : 3;
    return (eff + k) * (1 << sel);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_s1 = 1; m_s2 = 1; m_f = 1;
      e_drive = 0; e_rise = 0; e_fall = 0;
    end else begin
      bit old_f;
      old_f  = m_f;
      e_rise = 0;
      e_fall = 0;
      if (!xfer_active || soft_reset) begin
        m_ph = 0; e_drive = 0;
      end else begin
        case (m_ph)
          0: begin m_ph = 1; m_rem = half_len(low_width, presc_sel); e_drive = 1; e_fall = 1; end
          1: begin m_rem--; if (m_rem == 0) begin m_ph = 2; e_drive = 0; end end
          2: if (old_f) begin m_ph = 3; m_rem = half_len(high_width, presc_sel); e_rise = 1; end
          default: begin
            m_rem--;
            if (m_rem == 0) begin
              m_ph = 1; m_rem = half_len(low_width, presc_sel); e_drive = 1; e_fall = 1;
            end
          end
        endcase
      end
      if (m_s1 == m_s2) m_f = m_s2;
      m_s2 = m_s1;
      m_s1 = smp_scl;
    end
  end

  always @(negedge clk) begin
    smp_scl = scl_in;
    if (rst_n && !done) begin
      check(scl_drive_low == e_drive, "R2 drive vs model", scl_drive_low, e_drive);
      check(scl_rise_stb == e_rise, "R9 rise strobe vs model", scl_rise_stb, e_rise);
      check(scl_fall_stb == e_fall, "R9 fall strobe vs model", scl_fall_stb, e_fall);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_fall();
    for (int i = 0; i < 20000; i++) begin
      if (scl_fall_stb) return;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 20000; i++) begin
      if (scl_rise_stb) return;
      @(negedge clk);
    end
  endtask

  task automatic measure(input string tl, input string th, input int sel, input int lw, input int hw);
    int n;
    wait_fall();
    n = 0;
    while (scl_drive_low && n < 20000) begin n++; @(negedge clk); end
    check(n == half_len(lw, sel), tl, n, half_len(lw, sel));
    wait_rise();
    n = 0;
    do begin @(negedge clk); n++; end while (!scl_fall_stb && n < 20000);
    check(n == half_len(hw, sel), th, n, half_len(hw, sel));
  endtask

  task automatic run_cfg(input int sel, input int lw, input int hw, input string tl, input string th);
    presc_sel = 3'(sel); low_width = 5'(lw); high_width = 5'(hw);
    xfer_active = 1'b1;
    @(negedge clk);
    check(scl_fall_stb == 1'b1, "R11 fall on start", scl_fall_stb, 1);
    measure(tl, th, sel, lw, hw);
    measure(tl, th, sel, lw, hw);
    xfer_active = 1'b0;
    @(negedge clk);
    check(!scl_drive_low && !scl_rise_stb && !scl_fall_stb, "R8 idle after end", scl_drive_low, 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    check(!scl_drive_low && !scl_rise_stb && !scl_fall_stb, "R1 in reset", scl_drive_low, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_drive_low && !scl_rise_stb && !scl_fall_stb, "R1 after reset", scl_drive_low, 0);
    repeat (3) @(negedge clk);
    check(!scl_drive_low, "R8 inactive stays released", scl_drive_low, 0);

    run_cfg(0, 5, 4, "R2 low sel0", "R4 high sel0");
    run_cfg(1, 6, 2, "R3 low sel1", "R4 high sel1");
    run_cfg(2, 3, 31, "R3 low sel2", "R4 high sel2 max");
    run_cfg(1, 0, 0, "R5 low zero width", "R5 high zero width");
    run_cfg(0, 31, 1, "R2 low max sel0", "R4 high min sel0");
    run_cfg(7, 2, 1, "R3 low sel7", "R4 high sel7");

    // stretching, glitch filter and rise latency
    presc_sel = 3'd0; low_width = 5'd2; high_width = 5'd2;
    xfer_active = 1'b1;
    @(negedge clk);
    stretch = 1'b1;
    while (scl_drive_low) @(negedge clk);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (scl_rise_stb) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R6 no rise while held low", seen, 0);
    stretch = 1'b0;
    @(negedge clk);
    stretch = 1'b1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      if (scl_rise_stb) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R7 one-cycle pulse ignored", seen, 0);
    stretch = 1'b0;
    n = 0;
    while (!scl_rise_stb && n < 50) begin @(negedge clk); n++; end
    check(n == 4, "R10 rise latency", n, 4);
    @(negedge clk);
    check(!scl_rise_stb, "R9 rise one cycle", scl_rise_stb, 0);

    // soft reset mid low half
    wait_fall();
    repeat (2) @(negedge clk);
    soft_reset = 1'b1;
    @(negedge clk);
    check(!scl_drive_low && !scl_fall_stb, "R8 soft reset releases", scl_drive_low, 0);
    repeat (4) @(negedge clk);
    check(!scl_drive_low, "R8 soft reset holds idle", scl_drive_low, 0);
    soft_reset = 1'b0;
    @(negedge clk);
    check(scl_fall_stb && scl_drive_low, "R11 restart after soft reset", scl_fall_stb, 1);
    measure("R2 low after restart", "R4 high after restart", 0, 2, 2);
    xfer_active = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule